// File: doc/BRIEF.md
# Fixed-Point Square Root by Reciprocal-Root Refinement

This unit takes an unsigned fixed-point operand and returns its square root in the same format. It uses only shifts, additions and multiplications, so no divider is needed. The operand is first scaled into the interval [0.5, 1) with a power-of-two exponent. A linear first guess of the reciprocal square root is refined by a fixed number of quadratic Newton steps. The refined reciprocal is multiplied by the scaled operand to give the root of the scaled value. That root is then rescaled by half the exponent, and an odd exponent adds a multiplication by a root-two constant. All intermediate quantities are 32-bit words with two integer bits and thirty fraction bits.

The interface is a start/done handshake. A `start` pulse in the idle state latches `operand`. After a fixed number of cycles, `done` pulses for one cycle and `root` carries the result. `root` holds that value until the next job completes. Latency depends only on the configuration, never on the operand value.

The controller walks through these states. IDLE goes to NORM on `start`. NORM goes to SEED. SEED goes to SQUARE. SQUARE goes to WEIGH, and WEIGH goes to UPDATE. UPDATE goes back to SQUARE until the last refinement step, then on to ROOT. ROOT goes to ODDFIX. ODDFIX goes to SCALE. SCALE goes to DONE, and DONE returns to IDLE. Every state lasts exactly one cycle except IDLE.

Top module: `sqrt_nr_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `done` is 0 and `root` is 0.
- R2: `operand` and `root` are both unsigned values with 16 fraction bits. For any operand A, `root` lies within one unit of E = floor(sqrt(A * 2^16)), either side.
- R3: `done` rises exactly 14 clock cycles after the rising edge that samples `start` in IDLE, whatever the operand. The count is three refinement steps of three cycles each, plus five.
- R4: An operand of zero yields `root` = 0, with the same 14-cycle latency.
- R5: `done` is high for exactly one cycle per accepted job.
- R6: `root` changes only when a job completes, and holds its value between completions.
- R7: While a job is in progress, `start` pulses and changes on `operand` are ignored. The running job keeps its operand and its latency, and no extra `done` follows.
- R8: Power-of-two operands 2^i, for i from 0 to 31, meet the R2 bound. This set covers even and odd exponents of both signs, so the root-two and inverse-root-two correction paths are both exercised.
- R9: Operands whose leading one sits in bit 31 meet the R2 bound, and so do operands whose leading one sits in bit 0. This includes 0xFFFFFFFF, 0x80000000 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a job; sampled only in IDLE |
| operand | input | 32 | Unsigned operand, 16 fraction bits |
| done | output | 1 | One-cycle pulse when `root` is updated |
| root | output | 32 | Square root, 16 fraction bits, held between jobs |

## Verification
A bad normalization shift or a wrong exponent shows up at `root` as an error of a factor near two or root two. It shows in the same job, 14 cycles after start, and the swept operand ranges and all 32 power-of-two inputs expose it at once. A slip in the refinement state or the step counter shows in two ways. One is a bounded error of many units. The other is `done` arriving at a cycle other than the fourteenth, which the bench counts directly. A controller that re-accepts `start` while busy shows up as a second `done` pulse or a result taken from the wrong operand.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
    // Internal word: 2 integer bits, 30 fraction bits
    localparam int QW = 32;
    localparam int QF = 30;
    typedef logic [QW-1:0] q_t;

    // Linear seed x0 = C0 - C1*a for 1/sqrt(a), a in [0.5, 1)
    localparam q_t SEED_C0  = 32'd1934560644;  // ~1.80170
    localparam q_t SEED_C1  = 32'd889516825;   // ~0.82843
    localparam q_t THREE_Q  = 32'hC000_0000;   // 3.0
    localparam q_t ROOT2_Q  = 32'd1518500250;  // sqrt(2)
    localparam q_t RROOT2_Q = 32'd759250125;   // 1/sqrt(2)

    typedef enum logic [3:0] {
        S_IDLE,
        S_NORM,
        S_SEED,
        S_SQUARE,
        S_WEIGH,
        S_UPDATE,
        S_ROOT,
        S_ODDFIX,
        S_SCALE,
        S_DONE
    } state_t;
endpackage

// File: rtl/rsq_norm.sv
`timescale 1ns/1ps
module rsq_norm
    import rsq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]         val,
    output logic [$clog2(DW)-1:0] msb_pos,
    output q_t                    frac,
    output logic                  is_zero
);
    localparam int POS_W  = $clog2(DW);
    localparam int WIDE_W = DW + QF;

    logic [WIDE_W-1:0] wide;
    logic              unused_top;

    // Leading-one search: the highest set bit wins
    always_comb begin
        msb_pos = '0;
        for (int i = 0; i < DW; i++) begin
            if (val[i]) msb_pos = POS_W'(i);
        end
    end

    // val * 2^(QF-1-pos): the value lands in [0.5, 1) of the internal word
    assign wide       = {val, {QF{1'b0}}} >> (msb_pos + 1);
    assign frac       = {2'b00, wide[QF-1:0]};
    assign is_zero    = ~|val;
    assign unused_top = ^wide[WIDE_W-1:QF];
endmodule

// File: rtl/rsq_qmul.sv
`timescale 1ns/1ps
module rsq_qmul
    import rsq_pkg::*;
(
    input  q_t   lhs,
    input  q_t   rhs,
    input  logic halve,
    output q_t   prod
);
    logic [2*QW-1:0] full;
    logic [2*QW-1:0] shifted;
    logic            unused_hi;

    assign full      = {{QW{1'b0}}, lhs} * {{QW{1'b0}}, rhs};
    // Product of two internal words, truncated; halve folds in the 0.5 of a Newton step
    assign shifted   = halve ? (full >> (QF + 1)) : (full >> QF);
    assign prod      = shifted[QW-1:0];
    assign unused_hi = ^shifted[2*QW-1:QW];
endmodule

// File: rtl/rsq_scale.sv
`timescale 1ns/1ps
module rsq_scale
    import rsq_pkg::*;
#(
    parameter int DW     = 32,
    parameter int FRAC_W = 16,
    parameter int EXP_W  = 7
) (
    input  q_t                       r,
    input  logic signed [EXP_W-1:0]  half_exp,
    output logic [DW-1:0]            y
);
    logic [2*QW-1:0] wide;
    logic            unused_hi;
    int              amt;

    // y = r * 2^(half_exp + FRAC_W - QF), built as (r << QW) >> amt
    always_comb begin
        amt  = QW + QF - FRAC_W - int'(half_exp);
        wide = {r, {QW{1'b0}}} >> amt;
    end

    assign y         = wide[DW-1:0];
    assign unused_hi = ^wide[2*QW-1:DW];
endmodule

// File: rtl/sqrt_nr_unit.sv
`timescale 1ns/1ps
module sqrt_nr_unit #(
    parameter int DATA_W   = 32,
    parameter int FRAC_W   = 16,
    parameter int NR_STEPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    output logic              done,
    output logic [DATA_W-1:0] root
);
    import rsq_pkg::*;

    localparam int POS_W   = $clog2(DATA_W);
    localparam int EXP_W   = POS_W + 2;
    localparam int STEP_W  = $clog2(NR_STEPS + 1);
    localparam int LATENCY = 3 * NR_STEPS + 5;
    localparam int CNT_W   = $clog2(LATENCY + 2);

    state_t state_q, state_d;

    logic [DATA_W-1:0]       opnd_q;
    q_t                      an_q;
    logic signed [EXP_W-1:0] k_q;
    logic                    zero_q;
    q_t                      x_q;
    q_t                      t_q;
    q_t                      r_q;
    logic [STEP_W-1:0]       step_q;
    logic [DATA_W-1:0]       root_q;
    logic                    done_q;

    logic [POS_W-1:0]        norm_pos;
    q_t                      norm_frac;
    logic                    norm_zero;
    logic signed [EXP_W-1:0] k_next;
    logic signed [EXP_W-1:0] half_exp;
    logic [DATA_W-1:0]       scaled;

    q_t   mul_a, mul_b, mul_y;
    logic mul_half;

    rsq_norm #(.DW(DATA_W)) u_norm (
        .val     (opnd_q),
        .msb_pos (norm_pos),
        .frac    (norm_frac),
        .is_zero (norm_zero)
    );

    rsq_qmul u_mul (
        .lhs   (mul_a),
        .rhs   (mul_b),
        .halve (mul_half),
        .prod  (mul_y)
    );

    rsq_scale #(.DW(DATA_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_scale (
        .r        (r_q),
        .half_exp (half_exp),
        .y        (scaled)
    );

    // Exponent k with value = a * 2^k, where a is the normalized operand
    assign k_next = $signed({2'b00, norm_pos}) + $signed(EXP_W'(1 - FRAC_W));

    // Even k: k/2. Odd positive k: (k-1)/2. Odd negative k: (k+1)/2.
    assign half_exp = (k_q >>> 1) + ((k_q[0] && k_q[EXP_W-1]) ? EXP_W'(1) : EXP_W'(0));

    // Single shared multiplier, operands picked by state
    always_comb begin
        mul_a    = '0;
        mul_b    = '0;
        mul_half = 1'b0;
        unique case (state_q)
            S_SEED:   begin mul_a = SEED_C1; mul_b = an_q; end
            S_SQUARE: begin mul_a = x_q;     mul_b = x_q;  end
            S_WEIGH:  begin mul_a = an_q;    mul_b = t_q;  end
            S_UPDATE: begin mul_a = x_q;     mul_b = THREE_Q - t_q; mul_half = 1'b1; end
            S_ROOT:   begin mul_a = an_q;    mul_b = x_q;  end
            S_ODDFIX: begin mul_a = r_q;     mul_b = k_q[EXP_W-1] ? RROOT2_Q : ROOT2_Q; end
            default:  begin end
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_NORM;
            S_NORM:   state_d = S_SEED;
            S_SEED:   state_d = S_SQUARE;
            S_SQUARE: state_d = S_WEIGH;
            S_WEIGH:  state_d = S_UPDATE;
            S_UPDATE: state_d = (step_q == STEP_W'(NR_STEPS - 1)) ? S_ROOT : S_SQUARE;
            S_ROOT:   state_d = S_ODDFIX;
            S_ODDFIX: state_d = S_SCALE;
            S_SCALE:  state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q <= '0;
            an_q   <= '0;
            k_q    <= '0;
            zero_q <= 1'b0;
            x_q    <= '0;
            t_q    <= '0;
            r_q    <= '0;
            step_q <= '0;
            root_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE:   if (start) opnd_q <= operand;
                S_NORM:   begin
                    an_q   <= norm_frac;
                    k_q    <= k_next;
                    zero_q <= norm_zero;
                end
                S_SEED:   begin
                    x_q    <= SEED_C0 - mul_y;
                    step_q <= '0;
                end
                S_SQUARE: t_q <= mul_y;
                S_WEIGH:  t_q <= mul_y;
                S_UPDATE: begin
                    x_q    <= mul_y;
                    step_q <= step_q + STEP_W'(1);
                end
                S_ROOT:   r_q <= mul_y;
                S_ODDFIX: if (k_q[0]) r_q <= mul_y;
                S_SCALE:  begin
                    root_q <= zero_q ? '0 : scaled;
                    done_q <= 1'b1;
                end
                S_DONE:   begin end
                default:  begin end
            endcase
        end
    end

    assign done = done_q;
    assign root = root_q;

    // Cycle counter since job acceptance, for the latency property
    logic [CNT_W-1:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           lat_cnt <= '0;
        else if (state_q == S_IDLE && start)  lat_cnt <= '0;
        else if (state_q != S_IDLE)           lat_cnt <= lat_cnt + CNT_W'(1);
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == CNT_W'(LATENCY)));

    p_zero_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_q) |-> (root == '0));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_root_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_SCALE) |=> $stable(root));

    p_operand_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(opnd_q));

    p_norm_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEED && !zero_q) |-> (an_q[QW-1:QF] == 2'b00 && an_q[QF-1]));

    // R2: the refined reciprocal root of a value in [0.5,1) lies in (1, sqrt 2]
    p_recip_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ROOT && !zero_q) |-> (x_q >= 32'h3FF0_0000 && x_q <= 32'h5A90_0000));
endmodule

// File: tb/sqrt_nr_unit_test.sv
`timescale 1ns/1ps
module sqrt_nr_unit_test;
    localparam int DW  = 32;
    localparam int FW  = 16;
    localparam int LAT = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [DW-1:0] operand;
    logic          done;
    logic [DW-1:0] root;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sqrt_nr_unit #(.DATA_W(DW), .FRAC_W(FW), .NR_STEPS(3)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .done    (done),
        .root    (root)
    );

    function automatic longint unsigned ref_root(input logic [31:0] a);
        longint unsigned v, lo, hi, mid;
        v  = longint'(a) << FW;
        lo = 0;
        hi = 64'h200_0000;
        while (hi - lo > 1) begin
            mid = (lo + hi) / 2;
            if (mid * mid <= v) lo = mid;
            else                hi = mid;
        end
        return lo;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input logic [31:0] a);
        longint unsigned e, got;
        e   = ref_root(a);
        got = longint'(root);
        check((got + 1 >= e) && (got <= e + 1), req, $sformatf("root of %0h", a), got, e);
    endtask

    task automatic run_one(input logic [31:0] a, input string req);
        int cyc;
        @(negedge clk);
        operand = a;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        operand = ~a;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == LAT, "R3", $sformatf("latency for %0h", a), cyc, LAT);
        check_near(req, a);
        if (a == 0) check(root == 0, "R4", "zero operand", root, 0);
        @(negedge clk);
        check(done == 1'b0, "R5", "done width", done, 0);
    endtask

    initial begin
        logic [31:0] lcg;
        logic [31:0] held;
        int          cyc;

        rst_n   = 1'b0;
        start   = 1'b0;
        operand = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(root == 0, "R1", "root in reset", root, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(root == 0, "R1", "root after reset", root, 0);

        // R4: zero operand
        run_one(32'd0, "R4");

        // R2: exhaustive sweep of small operands
        for (int i = 1; i < 4096; i++) run_one(32'(i), "R2");

        // R8: powers of two, both exponent parities and signs; R2 on neighbours
        for (int i = 0; i < 32; i++) begin
            run_one(32'd1 << i, "R8");
            run_one((32'd1 << i) - 32'd1, "R2");
        end

        // R9: leading one at the extremes
        run_one(32'hFFFF_FFFF, "R9");
        run_one(32'h8000_0000, "R9");
        run_one(32'h8000_0001, "R9");
        run_one(32'd1, "R9");

        // R2: scattered operands over the whole range
        lcg = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            run_one(lcg >> (i % 32), "R2");
        end

        // R6: result holds while idle
        run_one(32'd12345, "R2");
        held = root;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(root == held && !done, "R6", "root hold", root, held);
        end

        // R7: start and operand activity during a job are ignored
        @(negedge clk);
        operand = 32'h0009_0000;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 0;
        repeat (4) begin
            @(negedge clk);
            cyc++;
        end
        operand = 32'hFFFF_0000;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        operand = '0;
        cyc++;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == LAT, "R7", "latency with busy start", cyc, LAT);
        check_near("R7", 32'h0009_0000);
        held = root;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!done && root == held, "R7", "no extra done", done, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule